// File: doc/BRIEF.md
# PCIe Device Error Signaling Controller

This block runs the device-side flow for one detected PCI Express error at a time. Each event arrives on a valid/ready input and carries an error-status vector, a correctable flag, an advisory-capable flag and a 16-bit source ID. The block first checks that the event names exactly one supported error. It then sets the device-status and advanced error status bits, applying the correctable mask, the uncorrectable mask and the severity register. When the error is unmasked it asks an external header log to record it. Finally it decides whether an error message goes upstream, and at which severity.

Masks, severity and all reporting enables are plain input ports that an outer configuration space drives. A non-fatal error that the source marks as advisory is reported as a correctable advisory-non-fatal error. If the header log reports an overflow and the first message was sent, the block processes a second correctable event for the header-log-overflow bit in the following cycle. The input is held not-ready during that cycle.

Top module: `err_signal_ctrl`

## Requirements
- R1: The event vector is ANDed with the supported mask of its class (correctable or uncorrectable). Unless exactly one bit remains, the event is consumed with no status change, no log request and no message.
- R2: A correctable event sets dev_status[0] and its bit in cor_status. If that bit is set in cor_mask, no message follows.
- R3: A correctable message (msg_sev 2'b01) is sent only when ctl_cor_en is set. An unsupported-request event (uncorrectable bit UR_BIT, default 20) reported on the correctable path also needs ctl_ur_en.
- R4: The severity of an uncorrectable event is its bit in unc_sev (1 = fatal). Fatal sets dev_status[2] and non-fatal sets dev_status[1]. An unsupported-request event also sets dev_status[3].
- R5: A masked uncorrectable event (its bit set in unc_mask) still sets its unc_status bit, but raises no log request and sends no message.
- R6: An unmasked uncorrectable event raises log_req in its accept cycle, with log_status one-hot on the error bit, and sets its unc_status bit. A fatal message (2'b11) needs cmd_serr_en or ctl_fat_en. A non-fatal message (2'b10) needs cmd_serr_en or ctl_nf_en.
- R7: An unsupported-request uncorrectable event sends no message when both ctl_ur_en and cmd_serr_en are clear.
- R8: A non-fatal event with evt_maybe_adv set takes the correctable path. It sets cor_status bit ADV_BIT (default 13) and dev_status[0], not dev_status[1]. If that correctable bit is unmasked, it also sets the original unc_status bit and requests logging only when that bit is clear in unc_mask. A fatal event ignores evt_maybe_adv.
- R9: When log_ovf is high with a log request and the message is sent, evt_ready is low for the next cycle. In that cycle the block processes a correctable event for cor_status bit HLO_BIT (default 15) with the same source ID, and its message (if enabled) pulses one cycle after the first message.
- R10: A message is a one-cycle msg_valid pulse, one cycle after the accept edge, carrying msg_sev and the event's msg_src. Back-to-back accepted events give back-to-back pulses.
- R11: After reset all status outputs and msg_valid are zero and evt_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Error event offered |
| evt_ready | output | 1 | Event can be accepted (low during follow-on overflow) |
| evt_status | input | 32 | Error-status vector, one bit expected |
| evt_is_cor | input | 1 | Event is of the correctable class |
| evt_maybe_adv | input | 1 | Non-fatal event may be reported as advisory |
| evt_src | input | 16 | Source ID of the requester |
| cor_mask | input | 32 | Correctable error mask |
| unc_mask | input | 32 | Uncorrectable error mask |
| unc_sev | input | 32 | Uncorrectable severity, 1 = fatal |
| ctl_cor_en | input | 1 | Correctable reporting enable |
| ctl_nf_en | input | 1 | Non-fatal reporting enable |
| ctl_fat_en | input | 1 | Fatal reporting enable |
| ctl_ur_en | input | 1 | Unsupported-request reporting enable |
| cmd_serr_en | input | 1 | System-error enable of the command register |
| log_req | output | 1 | Header-log record request (accept cycle) |
| log_status | output | 32 | One-hot error bit of the record |
| log_ovf | input | 1 | Log is full; valid while log_req is high |
| cor_status | output | 32 | Correctable error status (sticky) |
| unc_status | output | 32 | Uncorrectable error status (sticky) |
| dev_status | output | 4 | [0] correctable, [1] non-fatal, [2] fatal, [3] unsupported request detected |
| msg_valid | output | 1 | Message pulse |
| msg_sev | output | 2 | 01 correctable, 10 non-fatal, 11 fatal |
| msg_src | output | 16 | Source ID carried by the message |

## Verification
Two functions meet in the cycle after an overflowing event. The first message pulses while the internal header-log-overflow event updates the status and blocks the input. The bench provokes this by driving log_ovf with an enabled, unmasked fatal error. It then expects two queued messages on consecutive cycles, evt_ready low in between, and the overflow bit in cor_status. A second case accepts a new event in the same cycle as the previous message pulse. The scoreboard must then see two ordered pulses with their own source IDs.

// File: rtl/esc_pkg.sv
// Shared types for the error signaling controller.
// Assumes: message severity fits two bits; device status is four flags.
package esc_pkg;
    typedef enum logic [1:0] {
        SEV_NONE = 2'b00,
        SEV_COR  = 2'b01,
        SEV_NF   = 2'b10,
        SEV_FAT  = 2'b11
    } esc_sev_e;

    localparam int DS_W   = 4;
    localparam int DS_COR = 0;
    localparam int DS_NF  = 1;
    localparam int DS_FAT = 2;
    localparam int DS_UR  = 3;
endpackage

// File: rtl/esc_vet.sv
// Event validation: keeps only the supported bits of the event's class and
// flags whether exactly one bit survives.
// Assumes: the supported masks are fixed at elaboration.
module esc_vet #(
    parameter int               W       = 32,
    parameter logic [W-1:0]     COR_SUP = '1,
    parameter logic [W-1:0]     UNC_SUP = '1
) (
    input  logic [W-1:0] raw,
    input  logic         is_cor,
    output logic [W-1:0] vec,
    output logic         ok
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // per-bit class mask
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign vec[i] = raw[i] & (is_cor ? COR_SUP[i] : UNC_SUP[i]);
    end

    // exactly one bit left
    assign ok = (vec != '0) && ((vec & (vec - ONE)) == '0);
endmodule

// File: rtl/esc_decide.sv
// Signaling decision for one validated event: which status bits to set,
// whether to request logging, whether a message goes up and its severity.
// Assumes: vec is one-hot; purely combinational.
module esc_decide
    import esc_pkg::*;
#(
    parameter int W       = 32,
    parameter int UR_BIT  = 20,
    parameter int ADV_BIT = 13
) (
    input  logic [W-1:0]    vec,
    input  logic            is_cor,
    input  logic            maybe_adv,
    input  logic [W-1:0]    cor_mask,
    input  logic [W-1:0]    unc_mask,
    input  logic [W-1:0]    unc_sev,
    input  logic            cor_en,
    input  logic            nf_en,
    input  logic            fat_en,
    input  logic            ur_en,
    input  logic            serr_en,
    output logic [W-1:0]    cor_set,
    output logic [W-1:0]    unc_set,
    output logic [DS_W-1:0] dsta_set,
    output logic            log_want,
    output logic            send,
    output esc_sev_e        sev
);
    localparam logic [W-1:0] ADV_ONEHOT = {{(W-1){1'b0}}, 1'b1} << ADV_BIT;

    logic         is_ur;
    logic         fatal;
    logic [W-1:0] cvec;

    // class and severity of the event
    assign is_ur = !is_cor && vec[UR_BIT];
    assign fatal = !is_cor && ((vec & unc_sev) != '0);
    assign cvec  = is_cor ? vec : ADV_ONEHOT;

    // correctable / advisory path versus uncorrectable path
    always_comb begin
        cor_set  = '0;
        unc_set  = '0;
        dsta_set = '0;
        log_want = 1'b0;
        send     = 1'b0;
        sev      = SEV_NONE;
        if (is_cor || (!fatal && maybe_adv)) begin
            dsta_set[DS_COR] = 1'b1;
            dsta_set[DS_UR]  = is_ur;
            cor_set          = cvec;
            if ((cor_mask & cvec) == '0) begin
                if (!is_cor) begin
                    unc_set  = vec;
                    log_want = ((unc_mask & vec) == '0);
                end
                send = cor_en && !(is_ur && !ur_en);
                sev  = SEV_COR;
            end
        end else begin
            dsta_set[DS_FAT] = fatal;
            dsta_set[DS_NF]  = !fatal;
            dsta_set[DS_UR]  = is_ur;
            unc_set          = vec;
            if ((unc_mask & vec) == '0) begin
                log_want = 1'b1;
                if (is_ur && !ur_en && !serr_en) begin
                    send = 1'b0;
                end else begin
                    send = fatal ? (serr_en || fat_en) : (serr_en || nf_en);
                end
                sev = fatal ? SEV_FAT : SEV_NF;
            end
        end
    end
endmodule

// File: rtl/esc_regs.sv
// State of the controller: sticky status registers, the message pulse
// register and the pending follow-on overflow flag with its source ID.
// Assumes: go is high for exactly the cycles in which an event is processed.
module esc_regs
    import esc_pkg::*;
#(
    parameter int W     = 32,
    parameter int SRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [W-1:0]     cor_set,
    input  logic [W-1:0]     unc_set,
    input  logic [DS_W-1:0]  dsta_set,
    input  logic             send,
    input  esc_sev_e         sev,
    input  logic [SRC_W-1:0] src,
    input  logic             pend_nxt,
    output logic [W-1:0]     cor_status,
    output logic [W-1:0]     unc_status,
    output logic [DS_W-1:0]  dev_status,
    output logic             msg_valid,
    output esc_sev_e         msg_sev,
    output logic [SRC_W-1:0] msg_src,
    output logic             pend,
    output logic [SRC_W-1:0] pend_src
);
    // status accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cor_status <= '0;
            unc_status <= '0;
            dev_status <= '0;
        end else if (go) begin
            cor_status <= cor_status | cor_set;
            unc_status <= unc_status | unc_set;
            dev_status <= dev_status | dsta_set;
        end
    end

    // one-cycle message pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_sev   <= SEV_NONE;
            msg_src   <= '0;
        end else begin
            msg_valid <= go && send;
            msg_sev   <= (go && send) ? sev : SEV_NONE;
            msg_src   <= (go && send) ? src : '0;
        end
    end

    // follow-on overflow event bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_src <= '0;
        end else begin
            pend <= pend_nxt;
            if (pend_nxt) begin
                pend_src <= src;
            end
        end
    end

    p_pulse_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(go));
endmodule

// File: rtl/err_signal_ctrl.sv
// PCIe device error signaling controller (top).
// Accepts one error event per handshake, validates it, updates status,
// requests header logging, issues the upstream message and, on log overflow,
// runs a correctable header-log-overflow event in the following cycle.
// Assumes: log_ovf is a same-cycle answer to log_req; HLO_BIT and ADV_BIT
// are supported correctable bits.
module err_signal_ctrl
    import esc_pkg::*;
#(
    parameter int                W       = 32,
    parameter int                SRC_W   = 16,
    parameter logic [W-1:0]      COR_SUP = 32'h0000_F1C1,
    parameter logic [W-1:0]      UNC_SUP = 32'h003F_F030,
    parameter int                UR_BIT  = 20,
    parameter int                ADV_BIT = 13,
    parameter int                HLO_BIT = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    output logic             evt_ready,
    input  logic [W-1:0]     evt_status,
    input  logic             evt_is_cor,
    input  logic             evt_maybe_adv,
    input  logic [SRC_W-1:0] evt_src,
    input  logic [W-1:0]     cor_mask,
    input  logic [W-1:0]     unc_mask,
    input  logic [W-1:0]     unc_sev,
    input  logic             ctl_cor_en,
    input  logic             ctl_nf_en,
    input  logic             ctl_fat_en,
    input  logic             ctl_ur_en,
    input  logic             cmd_serr_en,
    output logic             log_req,
    output logic [W-1:0]     log_status,
    input  logic             log_ovf,
    output logic [W-1:0]     cor_status,
    output logic [W-1:0]     unc_status,
    output logic [DS_W-1:0]  dev_status,
    output logic             msg_valid,
    output logic [1:0]       msg_sev,
    output logic [SRC_W-1:0] msg_src
);
    localparam logic [W-1:0] HLO_ONEHOT = {{(W-1){1'b0}}, 1'b1} << HLO_BIT;

    logic             pend;
    logic [SRC_W-1:0] pend_src;
    logic             accept;
    logic [W-1:0]     sel_raw;
    logic             sel_cor;
    logic             sel_adv;
    logic [SRC_W-1:0] sel_src;
    logic [W-1:0]     vec;
    logic             ok;
    logic             go;
    logic [W-1:0]     cor_set;
    logic [W-1:0]     unc_set;
    logic [DS_W-1:0]  dsta_set;
    logic             log_want;
    logic             send;
    esc_sev_e         sev;
    esc_sev_e         msg_sev_e;
    logic             pend_nxt;

    // handshake: blocked only while the follow-on event runs
    assign evt_ready = !pend;
    assign accept    = evt_valid && evt_ready;

    // event source: external event or internal overflow event
    assign sel_raw = pend ? HLO_ONEHOT : evt_status;
    assign sel_cor = pend || evt_is_cor;
    assign sel_adv = !pend && evt_maybe_adv;
    assign sel_src = pend ? pend_src : evt_src;

    esc_vet #(
        .W       (W),
        .COR_SUP (COR_SUP),
        .UNC_SUP (UNC_SUP)
    ) u_vet (
        .raw    (sel_raw),
        .is_cor (sel_cor),
        .vec    (vec),
        .ok     (ok)
    );

    esc_decide #(
        .W       (W),
        .UR_BIT  (UR_BIT),
        .ADV_BIT (ADV_BIT)
    ) u_decide (
        .vec       (vec),
        .is_cor    (sel_cor),
        .maybe_adv (sel_adv),
        .cor_mask  (cor_mask),
        .unc_mask  (unc_mask),
        .unc_sev   (unc_sev),
        .cor_en    (ctl_cor_en),
        .nf_en     (ctl_nf_en),
        .fat_en    (ctl_fat_en),
        .ur_en     (ctl_ur_en),
        .serr_en   (cmd_serr_en),
        .cor_set   (cor_set),
        .unc_set   (unc_set),
        .dsta_set  (dsta_set),
        .log_want  (log_want),
        .send      (send),
        .sev       (sev)
    );

    // processing strobe and log request
    assign go         = pend || (accept && ok);
    assign log_req    = go && log_want;
    assign log_status = log_req ? vec : '0;

    // follow-on only after a sent message whose log overflowed
    assign pend_nxt = accept && ok && log_want && log_ovf && send;

    esc_regs #(
        .W     (W),
        .SRC_W (SRC_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .cor_set    (cor_set),
        .unc_set    (unc_set),
        .dsta_set   (dsta_set),
        .send       (send),
        .sev        (sev),
        .src        (sel_src),
        .pend_nxt   (pend_nxt),
        .cor_status (cor_status),
        .unc_status (unc_status),
        .dev_status (dev_status),
        .msg_valid  (msg_valid),
        .msg_sev    (msg_sev_e),
        .msg_src    (msg_src),
        .pend       (pend),
        .pend_src   (pend_src)
    );

    assign msg_sev = msg_sev_e;

    p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ok) |=> (!msg_valid && $stable(cor_status)
                             && $stable(unc_status) && $stable(dev_status)));

    p_masked_nolog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !evt_is_cor && ((evt_status & UNC_SUP & unc_mask) != '0))
            |-> !log_req);

    p_log_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |-> $onehot(log_status));

    p_block_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_ready |-> $past(log_req && log_ovf));

    p_block_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_ready |=> evt_ready);

    p_sev_coded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_sev != 2'b00));
endmodule

// File: tb/err_signal_ctrl_tb.sv
// Scoreboard bench: the driver queues expected messages, the monitor pops
// them on each message pulse; status outputs are checked after each event.
module err_signal_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [31:0] evt_status = '0;
    logic        evt_is_cor = 1'b0;
    logic        evt_maybe_adv = 1'b0;
    logic [15:0] evt_src = '0;
    logic [31:0] cor_mask = '0;
    logic [31:0] unc_mask = '0;
    logic [31:0] unc_sev = '0;
    logic        ctl_cor_en = 1'b0;
    logic        ctl_nf_en = 1'b0;
    logic        ctl_fat_en = 1'b0;
    logic        ctl_ur_en = 1'b0;
    logic        cmd_serr_en = 1'b0;
    logic        log_req;
    logic [31:0] log_status;
    logic        log_ovf = 1'b0;
    logic [31:0] cor_status;
    logic [31:0] unc_status;
    logic [3:0]  dev_status;
    logic        msg_valid;
    logic [1:0]  msg_sev;
    logic [15:0] msg_src;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [17:0] sb[$];

    always #10 clk = ~clk;

    err_signal_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_status(evt_status), .evt_is_cor(evt_is_cor),
        .evt_maybe_adv(evt_maybe_adv), .evt_src(evt_src),
        .cor_mask(cor_mask), .unc_mask(unc_mask), .unc_sev(unc_sev),
        .ctl_cor_en(ctl_cor_en), .ctl_nf_en(ctl_nf_en),
        .ctl_fat_en(ctl_fat_en), .ctl_ur_en(ctl_ur_en),
        .cmd_serr_en(cmd_serr_en),
        .log_req(log_req), .log_status(log_status), .log_ovf(log_ovf),
        .cor_status(cor_status), .unc_status(unc_status),
        .dev_status(dev_status),
        .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: every pulse must match the oldest expected message
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            if (sb.size() == 0) begin
                chk("R10 unexpected message", {14'd0, msg_sev, msg_src}, 32'h0);
            end else begin
                logic [17:0] e;
                e = sb.pop_front();
                chk("R10 message sev/src", {14'd0, msg_sev, msg_src},
                    {14'd0, e});
            end
        end
    end

    task automatic do_reset();
        evt_valid = 1'b0;
        cor_mask = '0; unc_mask = '0; unc_sev = '0;
        ctl_cor_en = 0; ctl_nf_en = 0; ctl_fat_en = 0; ctl_ur_en = 0;
        cmd_serr_en = 0; log_ovf = 0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one event; expectations: log request, message, blocked cycle, follow-on msg
    task automatic send(input string tag, input logic [31:0] st,
                        input logic c, input logic a, input logic [15:0] s,
                        input logic ovf, input logic exp_log,
                        input logic exp_msg, input logic [1:0] exp_sev,
                        input logic exp_block, input logic exp_follow);
        @(negedge clk);
        evt_valid = 1'b1; evt_status = st; evt_is_cor = c;
        evt_maybe_adv = a; evt_src = s; log_ovf = ovf;
        #2;
        chk({tag, " log_req"}, {31'd0, log_req}, {31'd0, exp_log});
        if (exp_msg) sb.push_back({exp_sev, s});
        if (exp_follow) sb.push_back({2'b01, s});
        @(negedge clk);
        evt_valid = 1'b0; log_ovf = 1'b0;
        chk({tag, " ready"}, {31'd0, evt_ready}, {31'd0, !exp_block});
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 cor_status", cor_status, 0);
        chk("R11 unc_status", unc_status, 0);
        chk("R11 dev_status", {28'd0, dev_status}, 0);
        chk("R11 msg_valid", {31'd0, msg_valid}, 0);
        chk("R11 ready", {31'd0, evt_ready}, 1);

        // R1 rejections: two supported bits, unsupported-only bit
        ctl_cor_en = 1; cmd_serr_en = 1;
        send("R1 two bits", 32'h0000_0041, 1, 0, 16'h0101, 0, 0, 0, 0, 0, 0);
        send("R1 unsupported", 32'h0000_0001, 0, 0, 16'h0102, 0, 0, 0, 0, 0, 0);
        send("R1 empty", 32'h0, 1, 0, 16'h0103, 0, 0, 0, 0, 0, 0);
        chk("R1 cor_status", cor_status, 0);
        chk("R1 unc_status", unc_status, 0);
        chk("R1 dev_status", {28'd0, dev_status}, 0);

        // R2/R3 correctable path; unsupported bit 1 dropped by class mask
        do_reset();
        send("R3 cor disabled", 32'h0000_0042, 1, 0, 16'h0201, 0, 0, 0, 0, 0, 0);
        chk("R2 cor bit6", cor_status, 32'h40);
        chk("R2 dev cor", {28'd0, dev_status}, 32'h1);
        ctl_cor_en = 1;
        send("R3 cor enabled", 32'h0000_0080, 1, 0, 16'h1234, 0, 0, 1, 2'b01, 0, 0);
        cor_mask = 32'h100;
        send("R2 cor masked", 32'h0000_0100, 1, 0, 16'h0203, 0, 0, 0, 0, 0, 0);
        chk("R2 cor bits", cor_status, 32'h1C0);

        // R4/R6 uncorrectable severity and enables
        do_reset();
        unc_sev = 32'h10; ctl_fat_en = 1;
        send("R6 fatal", 32'h10, 0, 0, 16'hA001, 0, 1, 1, 2'b11, 0, 0);
        chk("R4 dev fatal", {28'd0, dev_status}, 32'h4);
        send("R6 nf no enable", 32'h1000, 0, 0, 16'hA002, 0, 1, 0, 0, 0, 0);
        chk("R4 dev nf", {28'd0, dev_status}, 32'h6);
        cmd_serr_en = 1;
        send("R6 nf via serr", 32'h4000, 0, 0, 16'hA003, 0, 1, 1, 2'b10, 0, 0);
        // R5 masked uncorrectable
        unc_mask = 32'h1_0000;
        send("R5 masked", 32'h1_0000, 0, 0, 16'hA004, 0, 0, 0, 0, 0, 0);
        chk("R5 unc_status", unc_status, 32'h1_5010);
        chk("R6 cor untouched", cor_status, 0);

        // R7 unsupported request suppression
        do_reset();
        ctl_nf_en = 1;
        send("R7 ur suppressed", 32'h10_0000, 0, 0, 16'hB001, 0, 1, 0, 0, 0, 0);
        chk("R4 dev ur+nf", {28'd0, dev_status}, 32'hA);
        ctl_ur_en = 1;
        send("R7 ur enabled", 32'h10_0000, 0, 0, 16'hB002, 0, 1, 1, 2'b10, 0, 0);

        // R8 advisory downgrade
        do_reset();
        ctl_cor_en = 1; ctl_fat_en = 1; unc_sev = 32'h20; unc_mask = 32'h4000;
        send("R8 adv logged", 32'h1000, 0, 1, 16'hC001, 0, 1, 1, 2'b01, 0, 0);
        chk("R8 cor adv bit", cor_status, 32'h2000);
        chk("R8 unc bit12", unc_status, 32'h1000);
        chk("R8 dev cor only", {28'd0, dev_status}, 32'h1);
        send("R8 adv unlogged", 32'h4000, 0, 1, 16'hC002, 0, 0, 1, 2'b01, 0, 0);
        chk("R8 unc bit14", unc_status, 32'h5000);
        send("R8 fatal ignores adv", 32'h20, 0, 1, 16'hC003, 0, 1, 1, 2'b11, 0, 0);
        chk("R8 dev fatal", {28'd0, dev_status}, 32'h5);
        cor_mask = 32'h2000;
        send("R8 adv cor-masked", 32'h8000, 0, 1, 16'hC004, 0, 0, 0, 0, 0, 0);
        chk("R8 unc bit15 untouched", unc_status, 32'h5020);

        // R9 overflow follow-on
        do_reset();
        unc_sev = 32'h30; ctl_fat_en = 1; ctl_cor_en = 1;
        send("R9 overflow", 32'h10, 0, 0, 16'hD001, 1, 1, 1, 2'b11, 1, 1);
        chk("R9 hlo bit", cor_status, 32'h8000);
        chk("R9 dev", {28'd0, dev_status}, 32'h5);
        ctl_cor_en = 0;
        send("R9 overflow quiet", 32'h20, 0, 0, 16'hD002, 1, 1, 1, 2'b11, 1, 0);
        do_reset();
        unc_sev = 32'h20;
        send("R9 no msg no follow", 32'h20, 0, 0, 16'hD003, 1, 1, 0, 0, 0, 0);
        chk("R9 hlo clear", cor_status, 32'h0);

        // R10 back-to-back accepts
        do_reset();
        ctl_cor_en = 1;
        @(negedge clk);
        evt_valid = 1; evt_is_cor = 1; evt_maybe_adv = 0;
        evt_status = 32'h40; evt_src = 16'hE001;
        sb.push_back({2'b01, 16'hE001});
        @(negedge clk);
        evt_status = 32'h80; evt_src = 16'hE002;
        sb.push_back({2'b01, 16'hE002});
        chk("R10 first pulse", {31'd0, msg_valid}, 1);
        @(negedge clk);
        evt_valid = 0;
        chk("R10 second pulse", {31'd0, msg_valid}, 1);
        repeat (3) @(negedge clk);
        chk("R10 queue drained", sb.size(), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule